// File: doc/BRIEF.md
# Bidirectional Timer with Output Compare

An 8-bit timer/counter for a single clock domain. It either counts upward, or sweeps up and back down, and advances only on cycles that its clock-select field enables: on every clock, on an external tick strobe from a shared prescaler, or not at all. On each counting step the count is tested against an active compare value. A match sets a sticky compare flag. The flag drives a maskable interrupt line and steers a waveform output used for PWM or frequency generation.

Software reaches the block through a small register port. One address holds the count, one the compare value, one the control fields (mode, clock select, interrupt mask), and one the flag. The compare value is double-buffered. In the two PWM modes a new compare value becomes active only when the count passes the top of its sweep, so a pulse width never changes mid-period. In the other modes the new value takes effect at once. The ceiling of the count is 0xFF, except in clear-on-match mode, where the active compare value is the ceiling.

Top module: `updown_timer`

## Requirements
- R1: After reset the count, buffered and active compare values, control fields, flag, read data, waveform and interrupt outputs are all zero, and the direction is upward.
- R2: Clock select (control bits 3:2) gives: 00 or 11 hold the count; 01 steps on every clock; 10 steps only in cycles where `tick_i` is high.
- R3: In mode 00 (control bits 1:0) the count goes 0..255, then wraps to 0, and the waveform output never changes.
- R4: In mode 10 a step whose count equals the active compare value loads 0 (otherwise the count increments and wraps past 255), and each such match toggles the waveform.
- R5: In mode 11 the count wraps 255 to 0. The step leaving 255 sets the waveform, and a match on any other step clears it; when both happen on the same step, setting wins.
- R6: In mode 01 the count rises to 255, then falls (255, 254, ...) to 0, then rises again (0, 1, ...).
- R7: In mode 01 a step at count 0 sets the waveform, a match while rising clears it, and a match while falling leaves it unchanged.
- R8: In modes 01 and 11 the active compare value copies the buffered value only on the step leaving 255 (while rising, in mode 01). In modes 00 and 10 the active value follows a compare write on the next cycle.
- R9: Every step whose count equals the active compare value sets the flag, in either direction, whatever the mask.
- R10: Writing 1 to bit 0 of address 3, or pulsing `irq_ack_i`, clears the flag. Writing 0 to that bit leaves it unchanged. A match in the same cycle wins over a clear.
- R11: `irq_o` is high exactly when the flag is set and the mask (control bit 4) is 1.
- R12: A write to address 0 loads the count and cancels that cycle's step and match. A write to address 0 or address 2 sets the direction back to upward.
- R13: Reads are registered one cycle: address 0 returns the count, 1 the buffered compare, 2 `{000, mask, clock select, mode}`, 3 `{0000000, flag}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaler step strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Registered read data |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| irq_o | output | 1 | Masked compare interrupt |
| wave_o | output | 1 | Waveform output |

## Verification
The hardest situation to reach is a collision at the turning point of the up/down sweep. In it, a compare write, the deferred copy into the active register, a match and a flag clear all fall within the few cycles around count 255 or 0. Most of those coincidences only happen after hundreds of steps, so long runs in each mode are followed by a random phase. That phase keeps the counter running while it scatters count writes, compare writes, mode changes, acknowledges and tick gaps. A behavioural model in the bench, checked every clock, catches whichever coincidence arises.

// File: rtl/utm_pkg.sv
package utm_pkg;
  typedef enum logic [1:0] {
    M_NORMAL = 2'd0,
    M_PHASE  = 2'd1,
    M_CTC    = 2'd2,
    M_FAST   = 2'd3
  } utm_mode_e;

  typedef enum logic [1:0] {
    CS_OFF  = 2'd0,
    CS_CLK  = 2'd1,
    CS_TICK = 2'd2,
    CS_RSVD = 2'd3
  } utm_csel_e;

  localparam logic [1:0] A_COUNT = 2'd0;
  localparam logic [1:0] A_CMP   = 2'd1;
  localparam logic [1:0] A_CTRL  = 2'd2;
  localparam logic [1:0] A_FLAG  = 2'd3;

  function automatic logic is_pwm(utm_mode_e m);
    return (m == M_PHASE) || (m == M_FAST);
  endfunction
endpackage

// File: rtl/utm_ctrl_regs.sv
module utm_ctrl_regs
  import utm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         match,
  input  logic         irq_ack,
  output utm_mode_e    mode_q,
  output utm_csel_e    csel_q,
  output logic         ien_q,
  output logic [W-1:0] cmp_buf_q,
  output logic         flag_q,
  output logic         cnt_wr,
  output logic         cmp_wr,
  output logic         ctl_wr
);
  logic flg_wr;

  assign cnt_wr = wr_en && (wr_addr == A_COUNT);
  assign cmp_wr = wr_en && (wr_addr == A_CMP);
  assign ctl_wr = wr_en && (wr_addr == A_CTRL);
  assign flg_wr = wr_en && (wr_addr == A_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_NORMAL;
      csel_q    <= CS_OFF;
      ien_q     <= 1'b0;
      cmp_buf_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (ctl_wr) begin
        mode_q <= utm_mode_e'(wr_data[1:0]);
        csel_q <= utm_csel_e'(wr_data[3:2]);
        ien_q  <= wr_data[4];
      end
      if (cmp_wr) cmp_buf_q <= wr_data;
      // a fresh match outranks any clear in the same cycle
      if (match) flag_q <= 1'b1;
      else if ((flg_wr && wr_data[0]) || irq_ack) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/utm_count_unit.sv
module utm_count_unit
  import utm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dir_reset,
  input  utm_mode_e    mode,
  input  logic [W-1:0] active_cmp,
  output logic [W-1:0] cnt_q,
  output logic         up_q
);
  localparam logic [W-1:0] ONE      = W'(1);
  localparam logic [W-1:0] BOT      = '0;
  localparam logic [W-1:0] MAXV     = '1;
  localparam logic [W-1:0] NEAR_TOP = MAXV - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step) begin
      case (mode)
        M_CTC:   cnt_q <= (cnt_q == active_cmp) ? BOT : cnt_q + ONE;
        M_PHASE: begin
          if (up_q) cnt_q <= (cnt_q == MAXV) ? NEAR_TOP : cnt_q + ONE;
          else      cnt_q <= (cnt_q == BOT)  ? ONE      : cnt_q - ONE;
        end
        default: cnt_q <= cnt_q + ONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load || dir_reset || (mode != M_PHASE)) begin
      up_q <= 1'b1;
    end else if (step && up_q && (cnt_q == MAXV)) begin
      up_q <= 1'b0;
    end else if (step && !up_q && (cnt_q == BOT)) begin
      up_q <= 1'b1;
    end
  end
endmodule

// File: rtl/utm_compare_unit.sv
module utm_compare_unit
  import utm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  utm_mode_e    mode,
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  logic [W-1:0] cmp_buf,
  input  logic         cmp_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] active_q,
  output logic         match,
  output logic         wave_q
);
  localparam logic [W-1:0] BOT  = '0;
  localparam logic [W-1:0] MAXV = '1;

  logic at_max;
  logic pwm_load;

  assign at_max   = (cnt == MAXV);
  assign match    = step && (cnt == active_q);
  assign pwm_load = step && at_max && ((mode == M_FAST) || ((mode == M_PHASE) && up));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (is_pwm(mode)) begin
      if (pwm_load) active_q <= cmp_buf;
    end else begin
      active_q <= cmp_wr ? wr_data : cmp_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
    end else begin
      case (mode)
        M_CTC: if (match) wave_q <= ~wave_q;
        M_FAST: begin
          if (step && at_max) wave_q <= 1'b1;
          else if (match)     wave_q <= 1'b0;
        end
        M_PHASE: begin
          if (step && (cnt == BOT)) wave_q <= 1'b1;
          else if (match && up)     wave_q <= 1'b0;
        end
        default: wave_q <= wave_q;
      endcase
    end
  end
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import utm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             irq_ack_i,
  output logic             irq_o,
  output logic             wave_o
);
  utm_mode_e        mode_q;
  utm_csel_e        csel_q;
  logic             ien_q;
  logic [CNT_W-1:0] cmp_buf_q;
  logic             flag_q;
  logic             cnt_wr, cmp_wr, ctl_wr;
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic [CNT_W-1:0] active_q;
  logic             match;
  logic             run;
  logic             step;

  always_comb begin
    case (csel_q)
      CS_CLK:  run = 1'b1;
      CS_TICK: run = tick_i;
      default: run = 1'b0;
    endcase
  end

  assign step = run && !cnt_wr;

  utm_ctrl_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .match(match), .irq_ack(irq_ack_i), .mode_q(mode_q), .csel_q(csel_q),
    .ien_q(ien_q), .cmp_buf_q(cmp_buf_q), .flag_q(flag_q),
    .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .ctl_wr(ctl_wr)
  );

  utm_count_unit #(.W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .step(step), .load(cnt_wr), .load_val(wr_data_i),
    .dir_reset(ctl_wr), .mode(mode_q), .active_cmp(active_q),
    .cnt_q(cnt_q), .up_q(up_q)
  );

  utm_compare_unit #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .step(step), .mode(mode_q), .cnt(cnt_q), .up(up_q),
    .cmp_buf(cmp_buf_q), .cmp_wr(cmp_wr), .wr_data(wr_data_i),
    .active_q(active_q), .match(match), .wave_q(wave_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      case (rd_addr_i)
        A_COUNT: rd_data_o <= cnt_q;
        A_CMP:   rd_data_o <= cmp_buf_q;
        A_CTRL:  rd_data_o <= CNT_W'({ien_q, csel_q, mode_q});
        default: rd_data_o <= CNT_W'(flag_q);
      endcase
    end
  end

  assign irq_o = flag_q & ien_q;
endmodule

// File: rtl/utm_checker.sv
module utm_checker
  import utm_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         step,
  input logic         cnt_wr,
  input logic         ctl_wr,
  input utm_mode_e    mode_q,
  input utm_csel_e    csel_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] active_q,
  input logic         up_q,
  input logic         match,
  input logic         flag_q,
  input logic         ien_q,
  input logic         irq_o,
  input logic         wave_o
);
  localparam logic [W-1:0] MAXV     = '1;
  localparam logic [W-1:0] NEAR_TOP = MAXV - W'(1);

  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (csel_q == CS_OFF && !cnt_wr) |=> $stable(cnt_q));

  p_normal_wave_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_NORMAL) |=> $stable(wave_o));

  p_ctc_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_CTC && match) |=> (cnt_q == '0));

  p_phase_turn_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PHASE && step && up_q && cnt_q == MAXV && !ctl_wr)
      |=> (!up_q && cnt_q == NEAR_TOP));

  p_pwm_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((mode_q inside {M_PHASE, M_FAST}) && cnt_q != MAXV) |=> $stable(active_q));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    match |=> flag_q);

  p_irq_follow_r11: assert property (@(posedge clk) disable iff (rst)
    (match && ien_q && !ctl_wr) |=> irq_o);
endmodule

bind updown_timer utm_checker u_chk (
  .clk(clk), .rst(rst), .step(step), .cnt_wr(cnt_wr), .ctl_wr(ctl_wr),
  .mode_q(mode_q), .csel_q(csel_q), .cnt_q(cnt_q), .active_q(active_q),
  .up_q(up_q), .match(match), .flag_q(flag_q), .ien_q(ien_q),
  .irq_o(irq_o), .wave_o(wave_o)
);

// File: tb/updown_timer_test.sv
`timescale 1ns/1ps
module updown_timer_test;
  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, ack = 1'b0;
  logic [1:0] wa = 2'd0, ra = 2'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rd;
  logic       irq, wave;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit    live = 1'b0;

  bit [7:0] m_cnt, m_act, m_buf, m_rd;
  bit [1:0] m_mode, m_csel;
  bit       m_ien, m_flag, m_wave, m_up;

  always #2.5 clk = ~clk;

  updown_timer uut (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wa),
    .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd), .irq_ack_i(ack),
    .irq_o(irq), .wave_o(wave)
  );

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", t, $time, act, exp);
    end
  endtask

  task automatic model_tick();
    bit wc  = wr_en && wa == 2'd0;
    bit wcm = wr_en && wa == 2'd1;
    bit wct = wr_en && wa == 2'd2;
    bit wf  = wr_en && wa == 2'd3;
    bit run = (m_csel == 2'd1) || (m_csel == 2'd2 && tick);
    bit stp = run && !wc;
    bit hit = stp && (m_cnt == m_act);
    bit [7:0] n_cnt = m_cnt, n_act = m_act, n_buf = m_buf, n_rd;
    bit [1:0] n_mode = m_mode, n_csel = m_csel;
    bit n_ien = m_ien, n_flag = m_flag, n_wave = m_wave, n_up = m_up;
    case (ra)
      2'd0: n_rd = m_cnt;
      2'd1: n_rd = m_buf;
      2'd2: n_rd = {3'b000, m_ien, m_csel, m_mode};
      default: n_rd = {7'd0, m_flag};
    endcase
    if (wc) n_cnt = wd;
    else if (stp) begin
      if (m_mode == 2'd2) n_cnt = hit ? 8'd0 : m_cnt + 8'd1;
      else if (m_mode == 2'd1) begin
        if (m_up) n_cnt = (m_cnt == 8'd255) ? 8'd254 : m_cnt + 8'd1;
        else      n_cnt = (m_cnt == 8'd0) ? 8'd1 : m_cnt - 8'd1;
      end else n_cnt = m_cnt + 8'd1;
    end
    if (wc || wct || m_mode != 2'd1) n_up = 1'b1;
    else if (stp && m_up && m_cnt == 8'd255) n_up = 1'b0;
    else if (stp && !m_up && m_cnt == 8'd0) n_up = 1'b1;
    if (m_mode == 2'd1 || m_mode == 2'd3) begin
      if (stp && m_cnt == 8'd255 && (m_mode == 2'd3 || m_up)) n_act = m_buf;
    end else n_act = wcm ? wd : m_buf;
    if (wcm) n_buf = wd;
    if (wct) begin n_mode = wd[1:0]; n_csel = wd[3:2]; n_ien = wd[4]; end
    case (m_mode)
      2'd2: if (hit) n_wave = !m_wave;
      2'd3: if (stp && m_cnt == 8'd255) n_wave = 1'b1; else if (hit) n_wave = 1'b0;
      2'd1: if (stp && m_cnt == 8'd0) n_wave = 1'b1; else if (hit && m_up) n_wave = 1'b0;
      default: ;
    endcase
    if (hit) n_flag = 1'b1;
    else if ((wf && wd[0]) || ack) n_flag = 1'b0;
    m_cnt = n_cnt; m_act = n_act; m_buf = n_buf; m_rd = n_rd; m_mode = n_mode;
    m_csel = n_csel; m_ien = n_ien; m_flag = n_flag; m_wave = n_wave; m_up = n_up;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_act = 0; m_buf = 0; m_rd = 0; m_mode = 0; m_csel = 0;
      m_ien = 0; m_flag = 0; m_wave = 0; m_up = 1;
    end else model_tick();
  end

  always @(negedge clk) begin
    if (live) begin
      chk({tag, " rd_data"}, rd, m_rd);
      chk({tag, " wave"}, {7'd0, wave}, {7'd0, m_wave});
      chk({tag, " irq"}, {7'd0, irq}, {7'd0, m_flag & m_ien});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wa = a; wd = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=still running expected=finished");
    finish_run();
  end

  initial begin
    bit w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset rd_data", rd, 8'h00);
    chk("R1 reset wave", {7'd0, wave}, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    live = 1'b1;

    tag = "R13";
    ra = 2'd2; wr(2'd2, 8'h13); idle(2);
    chk("R13 control readback", rd, 8'h13);
    wr(2'd2, 8'hFF); idle(2);
    chk("R13 upper control bits read zero", rd, 8'h1F);
    ra = 2'd1; wr(2'd1, 8'h5A); idle(2);
    chk("R13 buffered compare readback", rd, 8'h5A);

    tag = "R2";
    wr(2'd2, 8'h00); wr(2'd0, 8'd5); ra = 2'd0; idle(10);
    chk("R2 stopped count holds", rd, 8'd5);
    wr(2'd2, 8'h08);
    for (int i = 0; i < 30; i++) begin tick = (i % 3 == 0); @(negedge clk); end
    tick = 1'b0; idle(2);
    chk("R2 counts only tick cycles", rd, 8'd15);
    wr(2'd2, 8'h04); idle(20);

    tag = "R3";
    wr(2'd1, 8'd252); wr(2'd0, 8'd250); w0 = wave; idle(30);
    chk("R3 wave unchanged in normal mode", {7'd0, wave}, {7'd0, w0});

    tag = "R4";
    wr(2'd1, 8'd6); wr(2'd0, 8'd0); wr(2'd2, 8'h06); idle(40);
    wr(2'd1, 8'd0); idle(10);
    wr(2'd1, 8'd3); wr(2'd0, 8'd100); idle(300);

    tag = "R5";
    wr(2'd1, 8'd100); wr(2'd2, 8'h07); idle(600);
    wr(2'd1, 8'd255); idle(600);
    wr(2'd1, 8'd0); idle(600);

    tag = "R8";
    ra = 2'd1; wr(2'd1, 8'd40); idle(1);
    chk("R8 buffer visible at once", rd, 8'd40);
    ra = 2'd0; idle(520);

    tag = "R6";
    wr(2'd1, 8'd50); wr(2'd2, 8'h05); idle(1100);
    tag = "R7";
    wr(2'd1, 8'd255); idle(1100);
    wr(2'd1, 8'd0); idle(600);

    tag = "R12";
    wr(2'd1, 8'd80); idle(300); wr(2'd0, 8'd200); idle(200); wr(2'd0, 8'd3); idle(50);

    tag = "R9";
    wr(2'd1, 8'd9); wr(2'd0, 8'd0); wr(2'd2, 8'h14); idle(12);
    wr(2'd2, 8'h10); idle(2);
    chk("R11 masked-in flag raises irq", {7'd0, irq}, 8'h01);
    tag = "R10";
    wr(2'd3, 8'h00); idle(1);
    chk("R10 writing zero keeps flag", {7'd0, irq}, 8'h01);
    wr(2'd3, 8'h01); idle(1);
    chk("R10 writing one clears flag", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'd0); wr(2'd2, 8'h14); idle(12); wr(2'd2, 8'h10);
    ack = 1'b1; @(negedge clk); ack = 1'b0; idle(1);
    chk("R10 acknowledge clears flag", {7'd0, irq}, 8'h00);

    tag = "R11";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      tick = 1'($urandom % 2);
      ack = (r < 3);
      ra = 2'($urandom % 4);
      if (r >= 96) wr(2'($urandom % 2), 8'($urandom));
      else if (r == 95) wr(2'd3, 8'($urandom));
      else if (r == 3 || r == 4)
        wr(2'd2, {3'b000, 1'($urandom % 2), ($urandom % 2) ? 2'b01 : 2'b10, 2'($urandom % 4)});
      else @(negedge clk);
    end
    ack = 1'b0; idle(3);
    finish_run();
  end
endmodule